// File: doc/BRIEF.md
# Key Scanner CPU Register Interface

This block is the processor-facing register file of a velocity-sensing key scanner. It sits on an 8-bit I/O bus with separate strobes. Two address lines act as chip enables: one is active high and one is active low. The low two address bits pick one of four registers, so the register set repeats across the whole decoded window.

On writes it captures three registers: an interrupt enable, an 8-bit scan-rate divider and a 2-bit scan mode. On reads it returns the following, taken from the scanning engine through plain ports:
- a bitmap of which key sections have a pending request;
- the 6-bit key address of the pending event;
- the closed, open and latched contact bits of each matrix.

The internal-matrix status register carries a fixed upper nibble. Software can use it to detect that the part is present.

The interrupt line is modelled as a pull-down enable. The bus access that ends a read of the address register produces a one-cycle release pulse, which tells the scanning engine to resume.

Top module: `kbregs_top`

## Requirements
- R1: A bus access is qualified only when selHigh=1, selLowN=0, iorqN=0 and m1N=1. Any other combination leaves every register unchanged and drives no read data.
- R2: regSel selects the register.
  - Write 0 stores dataIn[0] as the interrupt enable.
  - Write 1 stores dataIn[7:0] as the prescaler.
  - Write 2 stores dataIn[1:0] as the mode.
  - A write to register 3 changes nothing.
  - A write takes effect once, at the first clock edge at which the qualified wrN is low.
- R3: After reset, the interrupt enable, prescaler and mode outputs are all zero.
- R4: A qualified read of register 0 returns {5'b0, reqBits[2:0]}.
- R5: A qualified read of register 1 returns {2'b0, keyAddr[5:0]}.
- R6: A qualified read of register 2 returns {4'b0101, 1'b0, stat1[2:0]}. Each stat vector is ordered [2]=latched, [1]=open, [0]=closed.
- R7: A qualified read of register 3 returns {1'b0, stat3[2:0], 1'b0, stat2[2:0]}.
- R8: dataOutEn is high exactly while a qualified read (rdN=0) is present. dataOut is zero whenever dataOutEn is low.
- R9: irqPullDown is high exactly when the interrupt enable is 1 and any reqBits bit is 1.
- R10: releasePulse is high for exactly one cycle: the first cycle after a qualified read of register 1 ends. Reads of other registers and unqualified reads produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| selHigh | input | 1 | Active-high chip enable (upper address bit) |
| selLowN | input | 1 | Active-low chip enable (next address bit) |
| iorqN | input | 1 | Active-low I/O request |
| m1N | input | 1 | Active-low opcode-fetch indicator; low blocks access |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| regSel | input | 2 | Register select |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data |
| dataOutEn | output | 1 | Read data drive enable |
| reqBits | input | 3 | Pending request per key section |
| keyAddr | input | 6 | Key address of pending event |
| stat1 | input | 3 | Internal matrix contact status |
| stat2 | input | 3 | Matrix 2 contact status |
| stat3 | input | 3 | Matrix 3 contact status |
| intEnable | output | 1 | Stored interrupt enable |
| prescale | output | 8 | Stored scan-rate divider |
| scanMode | output | 2 | Stored scan mode |
| irqPullDown | output | 1 | Interrupt pull-down enable |
| releasePulse | output | 1 | One-cycle scan-resume acknowledge |

## Verification
The assertions check four things on every cycle:
- the prescaler never moves without a write strobe;
- read data is driven only while the read strobe is low;
- the signature nibble is present on every register-2 read;
- the release pulse never lasts beyond one cycle.

Only the bench scenarios can show the rest:
- that each chip-enable combination is rejected;
- that register 3 writes and repeated-cycle writes have no further effect;
- the exact bit placement of every read register;
- that reads of other registers produce no release pulse.

// File: rtl/kbregs_pkg.sv
package kbregs_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] REG_CTL  = 2'd0;
  localparam logic [SEL_W-1:0] REG_ADDR = 2'd1;
  localparam logic [SEL_W-1:0] REG_MODE = 2'd2;
  localparam logic [SEL_W-1:0] REG_ST2  = 2'd3;
  localparam logic [3:0] SIGNATURE = 4'b0101;

  typedef struct packed {
    logic wrIntCtl;
    logic wrPresc;
    logic wrMode;
    logic oe;
    logic [SEL_W-1:0] sel;
  } strobe_t;
endpackage

// File: rtl/kbregs_ctrl.sv
module kbregs_ctrl
  import kbregs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic selHigh,
  input  logic selLowN,
  input  logic iorqN,
  input  logic m1N,
  input  logic rdN,
  input  logic wrN,
  input  logic [SEL_W-1:0] regSel,
  output strobe_t stb,
  output logic releasePulse
);
  logic access, rdAct, wrAct, wrPrev, wrEdge, rd1Now, rd1Prev;

  always_comb begin
    access = selHigh & ~selLowN & ~iorqN & m1N;
    rdAct  = access & ~rdN;
    wrAct  = access & ~wrN;
    wrEdge = wrAct & ~wrPrev;
    rd1Now = rdAct && (regSel == REG_ADDR);
    stb.wrIntCtl = wrEdge && (regSel == REG_CTL);
    stb.wrPresc  = wrEdge && (regSel == REG_ADDR);
    stb.wrMode   = wrEdge && (regSel == REG_MODE);
    stb.oe  = rdAct;
    stb.sel = regSel;
    releasePulse = rd1Prev & ~rd1Now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPrev  <= 1'b0;
      rd1Prev <= 1'b0;
    end else begin
      wrPrev  <= wrAct;
      rd1Prev <= rd1Now;
    end
  end

  // R10: the acknowledge never stretches past one cycle
  a_r10_release_single: assert property (@(posedge clk) disable iff (!rst_n)
    releasePulse |=> !releasePulse);
  // R8: read data enable only while the read strobe is low
  a_r8_oe_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    stb.oe |-> (!rdN && !iorqN && m1N));
endmodule

// File: rtl/kbregs_dp.sv
module kbregs_dp
  import kbregs_pkg::*;
#(
  parameter int REQ_W = 3,
  parameter int KADDR_W = 6,
  parameter int ST_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  strobe_t stb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [REQ_W-1:0] reqBits,
  input  logic [KADDR_W-1:0] keyAddr,
  input  logic [ST_W-1:0] stat1,
  input  logic [ST_W-1:0] stat2,
  input  logic [ST_W-1:0] stat3,
  output logic [DATA_W-1:0] dataOut,
  output logic dataOutEn,
  output logic intEnable,
  output logic [DATA_W-1:0] prescale,
  output logic [1:0] scanMode,
  output logic irqPullDown
);
  logic [DATA_W-1:0] rdMux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intEnable <= 1'b0;
      prescale  <= '0;
      scanMode  <= '0;
    end else begin
      if (stb.wrIntCtl) intEnable <= dataIn[0];
      if (stb.wrPresc)  prescale  <= dataIn;
      if (stb.wrMode)   scanMode  <= dataIn[1:0];
    end
  end

  always_comb begin
    rdMux = '0;
    case (stb.sel)
      REG_CTL:  rdMux[REQ_W-1:0] = reqBits;
      REG_ADDR: rdMux[KADDR_W-1:0] = keyAddr;
      REG_MODE: begin
        rdMux[ST_W-1:0] = stat1;
        rdMux[7:4] = SIGNATURE;
      end
      default: begin
        rdMux[ST_W-1:0] = stat2;
        rdMux[4+ST_W-1:4] = stat3;
      end
    endcase
    dataOutEn   = stb.oe;
    dataOut     = stb.oe ? rdMux : '0;
    irqPullDown = intEnable & (|reqBits);
  end

  // R2: the divider only moves on its own write strobe
  a_r2_presc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.wrPresc |=> $stable(prescale));
  // R6: signature nibble present on every status-1 read
  a_r6_signature: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.oe && stb.sel == REG_MODE) |-> (dataOut[7:4] == 4'b0101));
  // R8: no data driven while not enabled
  a_r8_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !dataOutEn |-> (dataOut == '0));
endmodule

// File: rtl/kbregs_top.sv
module kbregs_top
  import kbregs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic selHigh,
  input  logic selLowN,
  input  logic iorqN,
  input  logic m1N,
  input  logic rdN,
  input  logic wrN,
  input  logic [1:0] regSel,
  input  logic [7:0] dataIn,
  output logic [7:0] dataOut,
  output logic dataOutEn,
  input  logic [2:0] reqBits,
  input  logic [5:0] keyAddr,
  input  logic [2:0] stat1,
  input  logic [2:0] stat2,
  input  logic [2:0] stat3,
  output logic intEnable,
  output logic [7:0] prescale,
  output logic [1:0] scanMode,
  output logic irqPullDown,
  output logic releasePulse
);
  strobe_t stb;

  kbregs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .selHigh(selHigh), .selLowN(selLowN),
    .iorqN(iorqN), .m1N(m1N), .rdN(rdN), .wrN(wrN), .regSel(regSel),
    .stb(stb), .releasePulse(releasePulse)
  );

  kbregs_dp #(.REQ_W(3), .KADDR_W(6), .ST_W(3)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .dataIn(dataIn),
    .reqBits(reqBits), .keyAddr(keyAddr), .stat1(stat1), .stat2(stat2),
    .stat3(stat3), .dataOut(dataOut), .dataOutEn(dataOutEn),
    .intEnable(intEnable), .prescale(prescale), .scanMode(scanMode),
    .irqPullDown(irqPullDown)
  );
endmodule

// File: tb/sim_kbregs_top.sv
module sim_kbregs_top;
  logic clk = 0, rst_n = 0;
  logic selHigh = 1, selLowN = 0, iorqN = 1, m1N = 1, rdN = 1, wrN = 1;
  logic [1:0] regSel = 0;
  logic [7:0] dataIn = 0;
  logic [2:0] reqBits = 0, stat1 = 0, stat2 = 0, stat3 = 0;
  logic [5:0] keyAddr = 0;
  logic [7:0] dataOut, prescale;
  logic dataOutEn, intEnable, irqPullDown, releasePulse;
  logic [1:0] scanMode;
  int vectors = 0, errs = 0;

  always #2 clk = ~clk;

  kbregs_top u0 (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [1:0] r, logic [7:0] d, logic hi, logic lo, logic m1);
    @(negedge clk);
    selHigh = hi; selLowN = lo; m1N = m1; iorqN = 0; wrN = 0; regSel = r; dataIn = d;
    @(negedge clk);
    @(negedge clk);
    wrN = 1; iorqN = 1; selHigh = 1; selLowN = 0; m1N = 1;
    @(negedge clk);
  endtask

  task automatic busRead(logic [1:0] r, logic hi, logic lo, logic m1, output logic [7:0] d, output logic en);
    @(negedge clk);
    selHigh = hi; selLowN = lo; m1N = m1; iorqN = 0; rdN = 0; regSel = r;
    #1; d = dataOut; en = dataOutEn;
    @(negedge clk);
  endtask

  task automatic endRead(output logic relNow, output logic relNext);
    rdN = 1; iorqN = 1; selHigh = 1; selLowN = 0; m1N = 1;
    #1; relNow = releasePulse;
    @(negedge clk); #1; relNext = releasePulse;
  endtask

  task automatic tReset;
    chk("R3 intEnable", {7'b0, intEnable}, 8'h00);
    chk("R3 prescale", prescale, 8'h00);
    chk("R3 scanMode", {6'b0, scanMode}, 8'h00);
    chk("R8 idle oe", {7'b0, dataOutEn}, 8'h00);
  endtask

  task automatic tWrites;
    busWrite(2'd1, 8'hA7, 1, 0, 1);
    chk("R2 prescale", prescale, 8'hA7);
    busWrite(2'd2, 8'hFE, 1, 0, 1);
    chk("R2 mode", {6'b0, scanMode}, 8'h02);
    busWrite(2'd0, 8'hFF, 1, 0, 1);
    chk("R2 int enable", {7'b0, intEnable}, 8'h01);
    busWrite(2'd3, 8'h00, 1, 0, 1);
    chk("R2 reg3 no effect presc", prescale, 8'hA7);
    chk("R2 reg3 no effect mode", {6'b0, scanMode}, 8'h02);
    chk("R2 reg3 no effect ie", {7'b0, intEnable}, 8'h01);
  endtask

  task automatic tDecode;
    busWrite(2'd1, 8'h11, 0, 0, 1);
    chk("R1 selHigh low ignored", prescale, 8'hA7);
    busWrite(2'd1, 8'h22, 1, 1, 1);
    chk("R1 selLowN high ignored", prescale, 8'hA7);
    busWrite(2'd1, 8'h33, 1, 0, 0);
    chk("R1 m1N low ignored", prescale, 8'hA7);
  endtask

  task automatic tReads;
    logic [7:0] d; logic en, rn, rx;
    reqBits = 3'b101; keyAddr = 6'h2B; stat1 = 3'b110; stat2 = 3'b011; stat3 = 3'b100;
    busRead(2'd0, 1, 0, 1, d, en); endRead(rn, rx);
    chk("R4 req read", d, 8'h05);
    chk("R8 oe during read", {7'b0, en}, 8'h01);
    chk("R10 no pulse reg0", {6'b0, rn, rx}, 8'h00);
    busRead(2'd2, 1, 0, 1, d, en); endRead(rn, rx);
    chk("R6 status1", d, 8'h56);
    busRead(2'd3, 1, 0, 1, d, en); endRead(rn, rx);
    chk("R7 status23", d, 8'h43);
    busRead(2'd1, 1, 0, 1, d, en); endRead(rn, rx);
    chk("R5 addr read", d, 8'h2B);
    chk("R10 pulse after addr read", {7'b0, rn}, 8'h01);
    chk("R10 pulse one cycle", {7'b0, rx}, 8'h00);
    busRead(2'd1, 0, 0, 1, d, en); endRead(rn, rx);
    chk("R1 unqualified read data", d, 8'h00);
    chk("R8 unqualified read oe", {7'b0, en}, 8'h00);
    chk("R10 no pulse unqualified", {6'b0, rn, rx}, 8'h00);
  endtask

  task automatic tIrq;
    reqBits = 3'b000; #1;
    chk("R9 no request", {7'b0, irqPullDown}, 8'h00);
    reqBits = 3'b010; #1;
    chk("R9 request enabled", {7'b0, irqPullDown}, 8'h01);
    busWrite(2'd0, 8'h00, 1, 0, 1);
    chk("R9 disabled", {7'b0, irqPullDown}, 8'h00);
  endtask

  initial begin
    #1000000;
    errs++; vectors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rst_n = 1;
    @(negedge clk);
    tWrites();
    tDecode();
    tReads();
    tIrq();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule